// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a small accumulator machine whose sequencing comes from a microprogram rather than from hardwired state logic. A micro-program counter steps through a control store. Each word of that store raises a set of one-hot strobes. The strobes choose which register drives a shared internal data bus and an address bus, and which registers capture the data. Every instruction starts with a common fetch-and-decode routine. That routine ends by loading the micro-program counter with a per-opcode start address produced by the decoder. The opcode's execute routine then runs, and on its last step the micro-program counter returns to the fetch routine.

The core talks to a word-addressed synchronous memory: read data appears on the cycle after the read strobe. It also drives byte-wide input and output ports and an external ALU. The ALU takes the accumulator and the B register as operands and returns a result and a flag vector. The core holds a program counter, an instruction register, an accumulator, a B operand register, a five-bit flag register and the micro-program counter.

Top module: `ucore_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the core issues a fetch read at memory address 0 with halted low. Reset clears PC, micro-PC, accumulator, B and flags, so a store run straight after reset writes 0 and a conditional jump is not taken.
- R2: An instruction word carries its opcode in bits 15:12 and its operand in bits 11:0. The opcodes are 0 NOP, 1 LDA, 2 STA, 3 ADD, 4 SUB, 5 IN, 6 OUT, 7 JMP, 8 JN, 9 HLT, A CMP, B JG, C JE, D JL. The unused codes E and F act as NOP.
- R3: Fetch and decode take 3 cycles: a memory read at PC, then IR capture with PC increment, then a micro-PC load from the decoder. A NOP takes 3 cycles in total.
- R4: LDA loads the accumulator from memory at the operand and takes 6 cycles. STA writes the accumulator to memory at the operand and takes 5 cycles.
- R5: ADD and SUB load B from memory at the operand, present the accumulator and B to the ALU with code 2 (ADD) or 3 (SUB), write the ALU result to the accumulator and the ALU flags to the flag register. Each takes 7 cycles.
- R6: CMP loads B, applies ALU code 1 and writes only the flag register; the accumulator is unchanged. It takes 7 cycles.
- R7: JMP writes the operand into PC and takes 5 cycles.
- R8: The flag register holds N, C, G, E, L in bits 4 to 0. JN tests bit 4, JG bit 2, JE bit 1 and JL bit 0. A set bit writes the operand into PC; a clear bit lets execution fall through. Both cases take 5 cycles.
- R9: IN reads the port numbered by operand bits 7:0 and loads the byte zero-extended into the accumulator. OUT writes accumulator bits 7:0 to that port. Each takes 4 cycles, and port read and write are never raised together.
- R10: After HLT is decoded, halted rises and stays high. From then until reset there is no memory access and PC does not change.
- R11: Memory read and memory write are never raised in the same cycle, and a memory write is always the last step of its instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address (address bus) |
| mem_rd | output | 1 | Memory read strobe; data returns next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (data bus) |
| mem_rdata | input | 16 | Memory read data |
| port_addr | output | 8 | I/O port number |
| port_rd | output | 1 | Port read strobe |
| port_wr | output | 1 | Port write strobe |
| port_wdata | output | 8 | Port write byte |
| port_rdata | input | 8 | Port read byte |
| alu_op | output | 2 | ALU code: 0 none, 1 compare, 2 add, 3 subtract |
| alu_x | output | 16 | ALU first operand (accumulator) |
| alu_y | output | 16 | ALU second operand (B register) |
| alu_res | input | 16 | ALU result |
| alu_flags | input | 5 | ALU flags {N,C,G,E,L} |
| halted | output | 1 | High once HLT has been decoded |

## Verification
A wrong micro-PC step or a misplaced strobe in the control store changes how many cycles a program needs to reach halted. Cycle counts for whole programs therefore expose a sequencing fault as soon as the run ends. A wrong decoder entry or a bad bus source sends a value to the wrong place, and this shows in memory words stored by STA or in the byte seen on the output port during the same program. Flag or branch faults make a skipped store execute, or a taken path be missed, and both change memory contents and the cycle count. A halted core that keeps running is caught within a few cycles because it accesses memory after halted.

// File: rtl/ucore_pkg.sv
package ucore_pkg;

    localparam int UPC_W  = 6;
    localparam int FLAG_W = 5;

    // flag register bit positions
    localparam int FB_N = 4;
    localparam int FB_C = 3;
    localparam int FB_G = 2;
    localparam int FB_E = 1;
    localparam int FB_L = 0;

    // opcodes
    localparam logic [3:0] OP_NOP = 4'h0;
    localparam logic [3:0] OP_LDA = 4'h1;
    localparam logic [3:0] OP_STA = 4'h2;
    localparam logic [3:0] OP_ADD = 4'h3;
    localparam logic [3:0] OP_SUB = 4'h4;
    localparam logic [3:0] OP_IN  = 4'h5;
    localparam logic [3:0] OP_OUT = 4'h6;
    localparam logic [3:0] OP_JMP = 4'h7;
    localparam logic [3:0] OP_JN  = 4'h8;
    localparam logic [3:0] OP_HLT = 4'h9;
    localparam logic [3:0] OP_CMP = 4'hA;
    localparam logic [3:0] OP_JG  = 4'hB;
    localparam logic [3:0] OP_JE  = 4'hC;
    localparam logic [3:0] OP_JL  = 4'hD;

    // microcode start addresses
    localparam logic [UPC_W-1:0] US_FETCH = 6'h00;
    localparam logic [UPC_W-1:0] US_LDA   = 6'h06;
    localparam logic [UPC_W-1:0] US_STA   = 6'h09;
    localparam logic [UPC_W-1:0] US_ADD   = 6'h0B;
    localparam logic [UPC_W-1:0] US_JMP   = 6'h0F;
    localparam logic [UPC_W-1:0] US_SUB   = 6'h11;
    localparam logic [UPC_W-1:0] US_CMP   = 6'h15;
    localparam logic [UPC_W-1:0] US_IN    = 6'h19;
    localparam logic [UPC_W-1:0] US_OUT   = 6'h1A;
    localparam logic [UPC_W-1:0] US_HLT   = 6'h1B;
    localparam logic [UPC_W-1:0] US_JN    = 6'h1C;
    localparam logic [UPC_W-1:0] US_JG    = 6'h1E;
    localparam logic [UPC_W-1:0] US_JE    = 6'h20;
    localparam logic [UPC_W-1:0] US_JL    = 6'h22;

    typedef enum logic [1:0] {
        ALU_NONE = 2'd0,
        ALU_CMP  = 2'd1,
        ALU_ADD  = 2'd2,
        ALU_SUB  = 2'd3
    } alu_op_e;

    // flag-select code for the branch mux
    typedef enum logic [1:0] {
        FSEL_N = 2'd0,
        FSEL_G = 2'd1,
        FSEL_E = 2'd2,
        FSEL_L = 2'd3
    } fsel_e;

    // one control-store word
    typedef struct packed {
        logic    pc_rd;    // PC drives address bus
        logic    pc_wr;    // PC loads from data bus
        logic    pc_inc;   // PC increments
        logic    ir_rd;    // IR operand drives address bus
        logic    opr_rd;   // IR operand drives data bus
        logic    ir_wr;    // IR loads from data bus
        logic    acc_rd;   // accumulator drives data bus
        logic    acc_wr;   // accumulator loads from data bus
        logic    b_wr;     // B loads from data bus
        logic    mem_rd;   // memory read request
        logic    mem_wr;   // memory write
        logic    mdr_rd;   // returned memory data drives data bus
        logic    alu_rd;   // ALU result drives data bus
        logic    flag_wr;  // flag register captures ALU flags
        logic    flag_rd;  // selected flag gates the PC write
        logic    port_rd;  // port byte drives data bus
        logic    port_wr;  // port write
        logic    dec_rd;   // decoder start address drives data bus
        logic    upc_wr;   // micro-PC loads from data bus
        logic    halt;     // micro-PC holds
        logic    done;     // last step: return to fetch
        alu_op_e alu_op;
        fsel_e   fsel;
    } uword_t;

endpackage

// File: rtl/ucore_decoder.sv
module ucore_decoder
    import ucore_pkg::*;
(
    input  logic [3:0]       opcode,
    output logic [UPC_W-1:0] start
);
    always_comb begin
        unique case (opcode)
            OP_LDA:  start = US_LDA;
            OP_STA:  start = US_STA;
            OP_ADD:  start = US_ADD;
            OP_SUB:  start = US_SUB;
            OP_IN:   start = US_IN;
            OP_OUT:  start = US_OUT;
            OP_JMP:  start = US_JMP;
            OP_JN:   start = US_JN;
            OP_HLT:  start = US_HLT;
            OP_CMP:  start = US_CMP;
            OP_JG:   start = US_JG;
            OP_JE:   start = US_JE;
            OP_JL:   start = US_JL;
            default: start = US_FETCH;   // NOP and unused codes R2
        endcase
    end
endmodule

// File: rtl/ucore_ctrl_store.sv
module ucore_ctrl_store
    import ucore_pkg::*;
(
    input  logic [UPC_W-1:0] upc,
    output uword_t           uw
);
    always_comb begin
        uw = '0;
        unique case (upc)
            // fetch / decode
            6'h00: begin uw.pc_rd = 1'b1; uw.mem_rd = 1'b1; end
            6'h01: begin uw.mdr_rd = 1'b1; uw.ir_wr = 1'b1; uw.pc_inc = 1'b1; end
            6'h02: begin uw.ir_rd = 1'b1; uw.dec_rd = 1'b1; uw.upc_wr = 1'b1; end
            // load accumulator
            6'h06: begin uw.ir_rd = 1'b1; end
            6'h07: begin uw.ir_rd = 1'b1; uw.mem_rd = 1'b1; end
            6'h08: begin uw.mdr_rd = 1'b1; uw.acc_wr = 1'b1; uw.done = 1'b1; end
            // store accumulator
            6'h09: begin uw.ir_rd = 1'b1; end
            6'h0A: begin uw.ir_rd = 1'b1; uw.acc_rd = 1'b1; uw.mem_wr = 1'b1;
                         uw.done = 1'b1; end
            // add
            6'h0B: begin uw.ir_rd = 1'b1; end
            6'h0C: begin uw.ir_rd = 1'b1; uw.mem_rd = 1'b1; end
            6'h0D: begin uw.mdr_rd = 1'b1; uw.b_wr = 1'b1; end
            6'h0E: begin uw.alu_op = ALU_ADD; uw.alu_rd = 1'b1; uw.acc_wr = 1'b1;
                         uw.flag_wr = 1'b1; uw.done = 1'b1; end
            // jump
            6'h0F: begin uw.ir_rd = 1'b1; end
            6'h10: begin uw.opr_rd = 1'b1; uw.pc_wr = 1'b1; uw.done = 1'b1; end
            // subtract
            6'h11: begin uw.ir_rd = 1'b1; end
            6'h12: begin uw.ir_rd = 1'b1; uw.mem_rd = 1'b1; end
            6'h13: begin uw.mdr_rd = 1'b1; uw.b_wr = 1'b1; end
            6'h14: begin uw.alu_op = ALU_SUB; uw.alu_rd = 1'b1; uw.acc_wr = 1'b1;
                         uw.flag_wr = 1'b1; uw.done = 1'b1; end
            // compare
            6'h15: begin uw.ir_rd = 1'b1; end
            6'h16: begin uw.ir_rd = 1'b1; uw.mem_rd = 1'b1; end
            6'h17: begin uw.mdr_rd = 1'b1; uw.b_wr = 1'b1; end
            6'h18: begin uw.alu_op = ALU_CMP; uw.flag_wr = 1'b1; uw.done = 1'b1; end
            // port input / output
            6'h19: begin uw.ir_rd = 1'b1; uw.port_rd = 1'b1; uw.acc_wr = 1'b1;
                         uw.done = 1'b1; end
            6'h1A: begin uw.ir_rd = 1'b1; uw.acc_rd = 1'b1; uw.port_wr = 1'b1;
                         uw.done = 1'b1; end
            // halt
            6'h1B: begin uw.halt = 1'b1; end
            // conditional jumps
            6'h1C: begin uw.ir_rd = 1'b1; uw.flag_rd = 1'b1; end
            6'h1D: begin uw.opr_rd = 1'b1; uw.flag_rd = 1'b1; uw.fsel = FSEL_N;
                         uw.pc_wr = 1'b1; uw.done = 1'b1; end
            6'h1E: begin uw.ir_rd = 1'b1; uw.flag_rd = 1'b1; end
            6'h1F: begin uw.opr_rd = 1'b1; uw.flag_rd = 1'b1; uw.fsel = FSEL_G;
                         uw.pc_wr = 1'b1; uw.done = 1'b1; end
            6'h20: begin uw.ir_rd = 1'b1; uw.flag_rd = 1'b1; end
            6'h21: begin uw.opr_rd = 1'b1; uw.flag_rd = 1'b1; uw.fsel = FSEL_E;
                         uw.pc_wr = 1'b1; uw.done = 1'b1; end
            6'h22: begin uw.ir_rd = 1'b1; uw.flag_rd = 1'b1; end
            6'h23: begin uw.opr_rd = 1'b1; uw.flag_rd = 1'b1; uw.fsel = FSEL_L;
                         uw.pc_wr = 1'b1; uw.done = 1'b1; end
            default: begin uw.done = 1'b1; end
        endcase
    end
endmodule

// File: rtl/ucore_flags.sv
module ucore_flags
    import ucore_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_wr,
    input  logic [FLAG_W-1:0] flags_in,
    input  fsel_e             fsel,
    output logic [FLAG_W-1:0] flags,
    output logic              cond
);
    logic [FLAG_W-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (flag_wr) flags_d = flags_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // 4-to-1 branch flag mux
    always_comb begin
        unique case (fsel)
            FSEL_N:  cond = flags_q[FB_N];
            FSEL_G:  cond = flags_q[FB_G];
            FSEL_E:  cond = flags_q[FB_E];
            default: cond = flags_q[FB_L];
        endcase
    end

    assign flags = flags_q;

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> $stable(flags_q)); // R6
endmodule

// File: rtl/ucore_top.sv
module ucore_top
    import ucore_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OPC_W  = 4,
    parameter int PORT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [DATA_W-OPC_W-1:0] mem_addr,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [PORT_W-1:0]       port_addr,
    output logic                    port_rd,
    output logic                    port_wr,
    output logic [PORT_W-1:0]       port_wdata,
    input  logic [PORT_W-1:0]       port_rdata,
    output logic [1:0]              alu_op,
    output logic [DATA_W-1:0]       alu_x,
    output logic [DATA_W-1:0]       alu_y,
    input  logic [DATA_W-1:0]       alu_res,
    input  logic [FLAG_W-1:0]       alu_flags,
    output logic                    halted
);
    localparam int ADDR_W = DATA_W - OPC_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] b;
        logic [UPC_W-1:0]  upc;
    } core_regs_t;

    core_regs_t r_d, r_q;

    uword_t             uw;
    logic [UPC_W-1:0]   dec_start;
    logic [FLAG_W-1:0]  flags;
    logic               cond;
    logic [DATA_W-1:0]  dbus;
    logic [ADDR_W-1:0]  abus;
    logic               pc_load;

    ucore_ctrl_store u_store (
        .upc (r_q.upc),
        .uw  (uw)
    );

    ucore_decoder u_dec (
        .opcode (r_q.ir[DATA_W-1 -: OPC_W]),
        .start  (dec_start)
    );

    ucore_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_wr  (uw.flag_wr),
        .flags_in (alu_flags),
        .fsel     (uw.fsel),
        .flags    (flags),
        .cond     (cond)
    );

    // address bus
    always_comb begin
        if (uw.pc_rd)      abus = r_q.pc;
        else if (uw.ir_rd) abus = r_q.ir[ADDR_W-1:0];
        else               abus = '0;
    end

    // data bus: one driver per step
    always_comb begin
        if (uw.mdr_rd)       dbus = mem_rdata;
        else if (uw.opr_rd)  dbus = DATA_W'(r_q.ir[ADDR_W-1:0]);
        else if (uw.acc_rd)  dbus = r_q.acc;
        else if (uw.alu_rd)  dbus = alu_res;
        else if (uw.port_rd) dbus = DATA_W'(port_rdata);
        else if (uw.dec_rd)  dbus = DATA_W'(dec_start);
        else                 dbus = '0;
    end

    assign pc_load = uw.pc_wr && (!uw.flag_rd || cond);

    always_comb begin
        r_d = r_q;
        if (pc_load)         r_d.pc = dbus[ADDR_W-1:0];
        else if (uw.pc_inc)  r_d.pc = r_q.pc + ADDR_W'(1);
        if (uw.ir_wr)        r_d.ir = dbus;
        if (uw.acc_wr)       r_d.acc = dbus;
        if (uw.b_wr)         r_d.b = dbus;
        if (uw.halt)         r_d.upc = r_q.upc;
        else if (uw.upc_wr)  r_d.upc = dbus[UPC_W-1:0];
        else if (uw.done)    r_d.upc = US_FETCH;
        else                 r_d.upc = r_q.upc + UPC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_addr   = abus;
    assign mem_rd     = uw.mem_rd;
    assign mem_wr     = uw.mem_wr;
    assign mem_wdata  = dbus;
    assign port_addr  = abus[PORT_W-1:0];
    assign port_rd    = uw.port_rd;
    assign port_wr    = uw.port_wr;
    assign port_wdata = dbus[PORT_W-1:0];
    assign alu_op     = uw.alu_op;
    assign alu_x      = r_q.acc;
    assign alu_y      = r_q.b;
    assign halted     = uw.halt;

    AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.upc == US_FETCH) |-> (mem_rd && mem_addr == r_q.pc)); // R3
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(r_q.pc) && !mem_rd && !mem_wr)); // R10
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R11
    AST_STORE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (r_q.upc == US_FETCH)); // R11
    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_rd && port_wr)); // R9
    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 2'd1) |=> $stable(r_q.acc)); // R6
endmodule

// File: tb/tb_ucore_top.sv
module tb_ucore_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [7:0]  port_addr;
    logic        port_rd, port_wr;
    logic [7:0]  port_wdata;
    logic [7:0]  port_rdata;
    logic [1:0]  alu_op;
    logic [15:0] alu_x, alu_y, alu_res;
    logic [4:0]  alu_flags;
    logic        halted;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] mem [256];
    int          post_halt_acc = 0;
    int          overlap = 0;
    int          port_wr_cnt = 0;
    logic [7:0]  last_paddr = '0;
    logic [7:0]  last_pdata = '0;
    logic [15:0] add_x = '0;
    logic [15:0] add_y = '0;

    always #2 clk = ~clk;

    ucore_top dut (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .port_addr(port_addr), .port_rd(port_rd), .port_wr(port_wr),
        .port_wdata(port_wdata), .port_rdata(port_rdata),
        .alu_op(alu_op), .alu_x(alu_x), .alu_y(alu_y),
        .alu_res(alu_res), .alu_flags(alu_flags), .halted(halted)
    );

    // synchronous memory model
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    assign port_rdata = port_addr + 8'h10;

    // external ALU model
    logic [16:0] alu_full;
    always_comb begin
        if (alu_op == 2'd2) alu_full = {1'b0, alu_x} + {1'b0, alu_y};
        else                alu_full = {1'b0, alu_x} - {1'b0, alu_y};
        alu_res   = alu_full[15:0];
        alu_flags = {alu_full[15], alu_full[16], alu_x > alu_y,
                     alu_x == alu_y, alu_x < alu_y};
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (halted && (mem_rd || mem_wr)) post_halt_acc <= post_halt_acc + 1;
            if (mem_rd && mem_wr) overlap <= overlap + 1;
            if (port_wr) begin
                port_wr_cnt <= port_wr_cnt + 1;
                last_paddr  <= port_addr;
                last_pdata  <= port_wdata;
            end
            if (alu_op == 2'd2) begin
                add_x <= alu_x;
                add_y <= alu_y;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    // reset, then run to halt; returns the cycle in which halted first shows
    task automatic run_prog(output int cyc);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        post_halt_acc = 0;
        overlap = 0;
        port_wr_cnt = 0;
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 fetch read in reset", {31'd0, mem_rd}, 32'd1);
        chk("R1 fetch address 0", {20'd0, mem_addr}, 32'd0);
        chk("R1 halted low", {31'd0, halted}, 32'd0);
    endtask

    task automatic t_arith();
        int cyc;
        clear_mem();
        mem[0] = 16'h0000;  // NOP           3
        mem[1] = 16'h1040;  // LDA 40        6
        mem[2] = 16'h3041;  // ADD 41        7
        mem[3] = 16'h2042;  // STA 42        5
        mem[4] = 16'h4041;  // SUB 41        7
        mem[5] = 16'h2043;  // STA 43        5
        mem[6] = 16'h9000;  // HLT           3
        mem[8'h40] = 16'h1234;
        mem[8'h41] = 16'h0F0F;
        run_prog(cyc);
        chk("R3 R4 R5 cycle count", cyc, 36);
        chk("R5 ADD result stored", {16'd0, mem[8'h42]}, 32'h2143);
        chk("R5 SUB result stored", {16'd0, mem[8'h43]}, 32'h1234);
        chk("R5 ALU x operand", {16'd0, add_x}, 32'h1234);
        chk("R5 ALU y operand", {16'd0, add_y}, 32'h0F0F);
        chk("R4 LDA source kept", {16'd0, mem[8'h40]}, 32'h1234);
        chk("R11 no read+write overlap", overlap, 0);
        // halt holds
        repeat (20) @(negedge clk);
        chk("R10 halted stays", {31'd0, halted}, 32'd1);
        chk("R10 no access after halt", post_halt_acc, 0);
    endtask

    task automatic t_branches();
        int cyc;
        clear_mem();
        mem[8'h00] = 16'h1040;  // LDA 40 (5)          6
        mem[8'h01] = 16'hA041;  // CMP 41 (5): E       7
        mem[8'h02] = 16'hC005;  // JE 05 taken         5
        mem[8'h03] = 16'h2050;  // skipped
        mem[8'h04] = 16'h9000;
        mem[8'h05] = 16'hA042;  // CMP 42 (9): N,L     7
        mem[8'h06] = 16'hB020;  // JG not taken        5
        mem[8'h07] = 16'hD009;  // JL taken            5
        mem[8'h08] = 16'h2051;  // skipped
        mem[8'h09] = 16'h800B;  // JN taken            5
        mem[8'h0A] = 16'h2052;  // skipped
        mem[8'h0B] = 16'hE000;  // unused code = NOP   3
        mem[8'h0C] = 16'h700E;  // JMP 0E              5
        mem[8'h0D] = 16'h2053;  // skipped
        mem[8'h0E] = 16'h2054;  // STA 54              5
        mem[8'h0F] = 16'h9000;  // HLT                 3
        mem[8'h40] = 16'h0005;
        mem[8'h41] = 16'h0005;
        mem[8'h42] = 16'h0009;
        run_prog(cyc);
        chk("R2 R7 R8 cycle count", cyc, 56);
        chk("R8 JE taken skips store", {16'd0, mem[8'h50]}, 32'd0);
        chk("R8 JL taken skips store", {16'd0, mem[8'h51]}, 32'd0);
        chk("R8 JN taken skips store", {16'd0, mem[8'h52]}, 32'd0);
        chk("R7 JMP skips store", {16'd0, mem[8'h53]}, 32'd0);
        chk("R6 CMP keeps accumulator", {16'd0, mem[8'h54]}, 32'd5);
    endtask

    task automatic t_ports();
        int cyc;
        clear_mem();
        mem[0] = 16'h1061;  // LDA 61 (FFFF)   6
        mem[1] = 16'h5033;  // IN 33 -> 43     4
        mem[2] = 16'h6007;  // OUT 07          4
        mem[3] = 16'h2060;  // STA 60          5
        mem[4] = 16'h9000;  // HLT             3
        mem[8'h61] = 16'hFFFF;
        run_prog(cyc);
        chk("R9 cycle count", cyc, 22);
        chk("R9 IN zero-extends", {16'd0, mem[8'h60]}, 32'h0043);
        chk("R9 one port write", port_wr_cnt, 1);
        chk("R9 OUT port number", {24'd0, last_paddr}, 32'h07);
        chk("R9 OUT data", {24'd0, last_pdata}, 32'h43);
    endtask

    task automatic t_reset_clears();
        int cyc;
        clear_mem();
        mem[0] = 16'h2070;  // STA 70 (acc cleared) 5
        mem[1] = 16'hD003;  // JL 03 not taken      5
        mem[2] = 16'h2071;  // STA 71               5
        mem[3] = 16'h9000;  // HLT                  3
        mem[8'h70] = 16'hBEEF;
        mem[8'h71] = 16'hBEEF;
        run_prog(cyc);
        chk("R1 cycle count", cyc, 18);
        chk("R1 accumulator cleared", {16'd0, mem[8'h70]}, 32'd0);
        chk("R1 flags cleared, JL falls through", {16'd0, mem[8'h71]}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_arith();
        t_branches();   // leaves N and L set before the next reset
        t_reset_clears();
        t_ports();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule